// File: doc/BRIEF.md
# Synchronous Byte Shift Port

This block is a full-duplex serial shifter for a microcontroller peripheral bus. Software loads a byte into the data register, programs the mode register and sets the start bit. The port then moves the loaded byte out on a serial-out line while it collects a byte from a serial-in line. Both directions use one shift clock. When the last bit is in, the received byte sits in the data register, the start bit drops and a completion flag is raised. If the interrupt is enabled, the flag also drives an interrupt line.

The shift clock either comes from an internal divider, with the port acting as master and driving the clock pin, or comes in on the clock pin from a remote master, with the port acting as slave. In slave mode the start bit only arms the port. Clock edges shift data only while the port is armed. The two ends have no handshake line, so the remote master must not begin until this port is armed. Bit order can be least- or most-significant first, and both ends must use the same order.

Mode register layout, used for both write and read: bit 0 is start, bit 1 selects the external clock, bit 2 selects MSB-first, bit 3 is the interrupt enable, bits 5:4 are the rate code, bit 6 reads 0, and bit 7 is the completion flag. Writing 1 to bit 7 leaves the flag unchanged.

Top module: `ssp_port`

## Requirements
- R1: After reset the mode register reads 0x00, the data register reads 0x00, sck_o and sdo are 1, sck_oe is 1 and irq is 0.
- R2: Setting mode bit 0 while idle starts a transfer of exactly 8 bits. After the 8th rising shift-clock edge, bit 0 reads 0 and the completion flag (bit 7) reads 1.
- R3: With the internal clock selected (mode bit 1 = 0), sck_oe is 1. The clock idles high, and each half period lasts 4^rate system cycles, giving a divisor of 2, 8, 32 or 128 for rate code 0 to 3 in bits 5:4. With the external clock selected, sck_oe is 0 and sck_o stays 1.
- R4: sdo changes only on a falling shift-clock edge, and serial input is captured on a rising edge. In master mode sdi is sampled directly. In slave mode sdi and sck_i each pass through two flip-flops first.
- R5: With mode bit 2 = 0, data bit 0 goes out first and received bits enter at bit 7, shifting toward bit 0. With bit 2 = 1, bit 7 goes out first and received bits enter at bit 0.
- R6: In slave mode, edges on sck_i while the start bit is 0 are ignored. The data register, sdo and the completion flag are all unchanged.
- R7: irq equals the completion flag ANDed with the interrupt enable (mode bit 3).
- R8: The completion flag is cleared by a mode write with bit 7 = 0, or by starting a transfer. A mode write with bit 7 = 1 leaves it unchanged.
- R9: A data-register write while a transfer is in progress is ignored.
- R10: Writing 0 to the start bit during a transfer aborts it. sck_o is high from the next cycle, the flag stays 0, no interrupt is raised, and a later start sends a full 8 bits again.
- R11: While a transfer is in progress, mode writes do not change the clock-select, order, interrupt-enable or rate fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the mode register, 1 selects the data register |
| wr_data | input | 8 | Write data |
| mode_rd | output | 8 | Mode register read value |
| data_rd | output | 8 | Data register read value |
| irq | output | 1 | Completion interrupt request |
| sck_o | output | 1 | Shift clock driven in master mode |
| sck_oe | output | 1 | Output enable for the clock pin |
| sck_i | input | 1 | Shift clock from a remote master |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest situations to reach are those where a bus write lands in the middle of a live transfer: an abort, a data write that must be dropped, or a mode write that must not move the configuration. Each one needs the port armed but not finished. The bench reaches this state in two ways. It arms a slave and sends no clock, so the transfer waits indefinitely. It also starts a master at the slowest rate and writes to the port a few hundred cycles later. A behavioural model that follows the bus writes and the pins is compared against every output on every clock, and the pins are driven by a bench master or slave.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   localparam int F_START   = 0;
   localparam int F_EXT     = 1;
   localparam int F_MSB     = 2;
   localparam int F_IE      = 3;
   localparam int F_RATE_LO = 4;
   localparam int F_DONE    = 7;

   typedef struct packed {
      logic [1:0] rate;
      logic       ie;
      logic       msb;
      logic       ext;
   } ssp_cfg_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ssp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
   parameter int RATE_W = 2,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              sck,
   output logic              fall_ev,
   output logic              rise_ev
);
   localparam int MAX_LOG = STEP * ((1 << RATE_W) - 1);
   localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

   if (RATE_W < 1 || STEP < 1) begin : g_bad_rate
      $error("ssp_clkgen: RATE_W and STEP must be positive");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   half_v;
   logic             wrap;
   logic             sck_r;

   always_comb begin
      half_v = {{CNT_W{1'b0}}, 1'b1} << (STEP * rate);
      wrap   = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) == half_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sck_r <= 1'b1;
      end else if (!run) begin
         cnt   <= '0;
         sck_r <= 1'b1;
      end else if (wrap) begin
         cnt   <= '0;
         sck_r <= ~sck_r;
      end else begin
         cnt   <= cnt + CNT_W'(1);
      end
   end

   assign fall_ev = run & wrap & sck_r;
   assign rise_ev = run & wrap & ~sck_r;
   assign sck     = sck_r | ~run;

   // R3: counter never passes the selected half period
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ({1'b0, cnt} < half_v));
   // R3: clock parks high once the divider stops
   a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sck_r);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         fall_ev,
   input  logic         rise_ev,
   input  logic         msb_first,
   input  logic         sin,
   output logic [W-1:0] q,
   output logic         sout
);
   if (W < 2) begin : g_bad_width
      $error("ssp_shifter: W must be at least 2");
   end

   logic out_bit;
   assign out_bit = msb_first ? q[W-1] : q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         sout <= 1'b1;
      end else begin
         if (load)
            q <= load_val;
         else if (rise_ev)
            q <= msb_first ? {q[W-2:0], sin} : {sin, q[W-1:1]};
         if (fall_ev)
            sout <= out_bit;
      end
   end

   // R9: a load never coincides with a shift event
   a_r9_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !(fall_ev || rise_ev));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
   import ssp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RATE_W      = 2,
   parameter int RATE_STEP   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] mode_rd,
   output logic [DATA_W-1:0] data_rd,
   output logic              irq,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sck_i,
   output logic              sdo,
   input  logic              sdi
);
   localparam int BIT_W = $clog2(DATA_W);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("ssp_port: DATA_W must hold the mode layout");
   end
   if (F_RATE_LO + RATE_W > F_DONE) begin : g_bad_rate_w
      $error("ssp_port: rate field overlaps the flag bit");
   end

   ssp_cfg_t         cfg_q;
   logic             start_q, done_q;
   logic [BIT_W-1:0] bitn;

   logic wr_mode, wr_dat, go, stop, last_bit;
   logic m_run, s_run;
   logic m_fall, m_rise, e_fall, e_rise, fall_g, rise_g;
   logic s_sck, s_sdi, sck_d, sin;

   assign wr_mode = wr_en & ~wr_sel;
   assign wr_dat  = wr_en & wr_sel;
   assign go      = wr_mode & wr_data[F_START] & ~start_q;
   assign stop    = wr_mode & ~wr_data[F_START] & start_q;
   assign m_run   = start_q & ~cfg_q.ext;
   assign s_run   = start_q & cfg_q.ext;

   ssp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck_i, sdi}), .q({s_sck, s_sdi}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b1;
      else        sck_d <= s_sck;
   end

   assign e_rise = s_run & s_sck & ~sck_d;
   assign e_fall = s_run & ~s_sck & sck_d;

   ssp_clkgen #(.RATE_W(RATE_W), .STEP(RATE_STEP)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(m_run), .rate(cfg_q.rate),
      .sck(sck_o), .fall_ev(m_fall), .rise_ev(m_rise));

   assign fall_g   = (m_fall | e_fall) & ~stop;
   assign rise_g   = (m_rise | e_rise) & ~stop;
   assign sin      = cfg_q.ext ? s_sdi : sdi;
   assign last_bit = (bitn == BIT_W'(DATA_W - 1));

   ssp_shifter #(.W(DATA_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .load(wr_dat & ~start_q), .load_val(wr_data),
      .fall_ev(fall_g), .rise_ev(rise_g), .msb_first(cfg_q.msb), .sin(sin),
      .q(data_rd), .sout(sdo));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
         bitn    <= '0;
      end else begin
         if (wr_mode && !start_q) begin
            cfg_q.ext  <= wr_data[F_EXT];
            cfg_q.msb  <= wr_data[F_MSB];
            cfg_q.ie   <= wr_data[F_IE];
            cfg_q.rate <= wr_data[F_RATE_LO +: RATE_W];
         end
         if (go) begin
            start_q <= 1'b1;
            bitn    <= '0;
         end else if (stop) begin
            start_q <= 1'b0;
            bitn    <= '0;
         end else if (rise_g) begin
            if (last_bit) begin
               start_q <= 1'b0;
               bitn    <= '0;
            end else begin
               bitn <= bitn + BIT_W'(1);
            end
         end
         if (go)
            done_q <= 1'b0;
         else if (rise_g && last_bit)
            done_q <= 1'b1;
         else if (wr_mode && !wr_data[F_DONE])
            done_q <= 1'b0;
      end
   end

   always_comb begin
      mode_rd = '0;
      mode_rd[F_START] = start_q;
      mode_rd[F_EXT]   = cfg_q.ext;
      mode_rd[F_MSB]   = cfg_q.msb;
      mode_rd[F_IE]    = cfg_q.ie;
      mode_rd[F_RATE_LO +: RATE_W] = cfg_q.rate;
      mode_rd[F_DONE]  = done_q;
   end

   assign irq    = done_q & cfg_q.ie;
   assign sck_oe = ~cfg_q.ext;

   // R2: the last captured bit ends the transfer
   a_r2_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_g && last_bit) |=> !start_q);
   // R7: the flag only rises as a running transfer finishes
   a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> ($past(start_q) && !start_q));
   // R6: idle port keeps its data without a data write
   a_r6_idle_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q && !wr_dat) |=> $stable(data_rd));
   // R10: abort leaves the port quiet
   a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!start_q && !done_q && sck_o && bitn == '0));
   // R11: configuration frozen while busy
   a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> $stable(cfg_q));
endmodule

// File: tb/test_ssp_port.sv
module test_ssp_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       sck_i = 1'b1;
   logic       sdi = 1'b1;
   logic [7:0] mode_rd, data_rd;
   logic       irq, sck_o, sck_oe, sdo;

   always #4 clk = ~clk;

   ssp_port i_ssp_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode_rd(mode_rd), .data_rd(data_rd), .irq(irq), .sck_o(sck_o),
      .sck_oe(sck_oe), .sck_i(sck_i), .sdo(sdo), .sdi(sdi));

   int n_checks = 0;
   int n_errs = 0;
   int cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   bit         e_start, e_done, e_ext, e_msb, e_ie;
   int         e_rate, e_el, e_bits;
   logic [7:0] e_sh;
   bit         e_sdo;
   bit         hs[4];
   bit         hd[4];
   bit         fe, re, pre, inb, wm, wdd, abort_m, go_m, fin;
   int         half_m;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_start = 0; e_done = 0; e_ext = 0; e_msb = 0; e_ie = 0;
         e_rate = 0; e_el = 0; e_bits = 0; e_sh = 8'h00; e_sdo = 1;
         for (int k = 0; k < 4; k++) begin hs[k] = 1; hd[k] = 1; end
      end else begin
         for (int k = 3; k > 0; k--) begin hs[k] = hs[k-1]; hd[k] = hd[k-1]; end
         hs[0] = sck_i; hd[0] = sdi;
         pre = e_start; fe = 0; re = 0; fin = 0;
         half_m = 1 << (2 * e_rate);
         if (pre && !e_ext) begin
            e_el++;
            if (e_el % half_m == 0) begin
               if (((e_el / half_m) % 2) == 1) fe = 1; else re = 1;
            end
         end
         if (pre && e_ext) begin
            fe = !hs[2] && hs[3];
            re = hs[2] && !hs[3];
         end
         wm  = wr_en && !wr_sel;
         wdd = wr_en && wr_sel;
         abort_m = wm && !wr_data[0] && pre;
         go_m    = wm && wr_data[0] && !pre;
         if (abort_m) begin
            e_start = 0; e_bits = 0; e_el = 0;
         end else begin
            if (fe) e_sdo = e_msb ? e_sh[7] : e_sh[0];
            if (re) begin
               inb  = e_ext ? hd[2] : sdi;
               e_sh = e_msb ? {e_sh[6:0], inb} : {inb, e_sh[7:1]};
               e_bits++;
               if (e_bits == 8) begin
                  e_start = 0; e_done = 1; e_bits = 0; e_el = 0; fin = 1;
               end
            end
         end
         if (wm && !pre) begin
            e_ext = wr_data[1]; e_msb = wr_data[2]; e_ie = wr_data[3];
            e_rate = int'(wr_data[5:4]);
         end
         if (go_m) begin
            e_start = 1; e_el = 0; e_bits = 0; e_done = 0;
         end else if (wm && !wr_data[7] && !fin) begin
            e_done = 0;
         end
         if (wdd && !pre) e_sh = wr_data;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic exp_sck;
         exp_sck = 1'b1;
         if (e_start && !e_ext)
            exp_sck = (((e_el / (1 << (2 * e_rate))) % 2) == 0);
         chk("R3 sck_o", 32'(sck_o), 32'(exp_sck));
         chk("R3 sck_oe", 32'(sck_oe), 32'(!e_ext));
         chk("R4 sdo", 32'(sdo), 32'(e_sdo));
         chk("R7 irq", 32'(irq), 32'(e_done && e_ie));
         chk("R2 mode_rd", 32'(mode_rd),
             32'({e_done, 1'b0, 2'(e_rate), e_ie, e_msb, e_ext, e_start}));
         chk("R5 data_rd", 32'(data_rd), 32'(e_sh));
      end
   end

   // ---------------- bench slave used when the port is master ----------------
   bit         peer_on = 0, peer_msb = 0;
   logic [7:0] peer_tx = 0, peer_rx = 0;
   int         peer_fall = 0, peer_rise = 0, gap_cnt = 0, first_gap = 0;
   logic       prev_sck = 1'b1;

   always @(negedge clk) begin
      if (peer_on) begin
         gap_cnt++;
         if (prev_sck && !sck_o) begin
            if (peer_fall < 8) sdi = peer_msb ? peer_tx[7 - peer_fall] : peer_tx[peer_fall];
            peer_fall++;
            gap_cnt = 0;
         end
         if (!prev_sck && sck_o) begin
            if (peer_rise == 0) first_gap = gap_cnt;
            peer_rx = peer_msb ? {peer_rx[6:0], sdo} : {sdo, peer_rx[7:1]};
            peer_rise++;
         end
      end
      prev_sck = sck_o;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
         summary();
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [7:0] mv(bit st, bit ext, bit msb, bit ie, int rate, bit keep);
      return {keep, 1'b0, 2'(rate), ie, msb, ext, st};
   endfunction

   task automatic wr(input bit sel, input logic [7:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!mode_rd[7] && t < 5000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] ptx,
                              input bit msb, input int rate, input bit ie);
      wr(1'b1, tx);
      wr(1'b0, mv(0, 0, msb, ie, rate, 1));
      peer_tx = ptx; peer_msb = msb; peer_rx = 0;
      peer_fall = 0; peer_rise = 0; first_gap = 0; peer_on = 1;
      wr(1'b0, mv(1, 0, msb, ie, rate, 1));
      chk("R8 start clears flag", 32'(mode_rd[7]), 32'd0);
      chk("R2 start bit set", 32'(mode_rd[0]), 32'd1);
      wait_done();
      repeat (2) @(negedge clk);
      chk("R4 remote received byte", 32'(peer_rx), 32'(tx));
      chk("R5 port received byte", 32'(data_rd), 32'(ptx));
      chk("R2 eight rising edges", 32'(peer_rise), 32'd8);
      chk("R3 half period", 32'(first_gap), 32'(1 << (2 * rate)));
      chk("R2 start bit cleared", 32'(mode_rd[0]), 32'd0);
      chk("R7 irq after done", 32'(irq), 32'(ie));
      peer_on = 0;
   endtask

   task automatic drive_ext(input logic [7:0] b, input bit msb, input int h,
                            output logic [7:0] cap);
      cap = 8'h00;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         sck_i = 1'b0;
         sdi = msb ? b[7 - k] : b[k];
         repeat (h) @(negedge clk);
         cap = msb ? {cap[6:0], sdo} : {sdo, cap[7:1]};
         sck_i = 1'b1;
         repeat (h - 1) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      logic [7:0] cap;
      logic       sdo_before;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode after reset", 32'(mode_rd), 32'h00);
      chk("R1 data after reset", 32'(data_rd), 32'h00);
      chk("R1 sck_o idle", 32'(sck_o), 32'd1);
      chk("R1 sdo idle", 32'(sdo), 32'd1);
      chk("R1 sck_oe", 32'(sck_oe), 32'd1);
      chk("R1 irq", 32'(irq), 32'd0);

      master_xfer(8'hA5, 8'h3C, 0, 0, 1);
      master_xfer(8'hA5, 8'h3C, 1, 1, 0);
      master_xfer(8'h81, 8'h7E, 1, 2, 1);
      master_xfer(8'hF0, 8'h0D, 0, 3, 1);

      wr(1'b0, mv(0, 0, 0, 1, 0, 1));
      chk("R8 flag kept with bit7=1", 32'(mode_rd[7]), 32'd1);
      wr(1'b0, mv(0, 0, 0, 1, 0, 0));
      chk("R8 flag cleared by write", 32'(mode_rd[7]), 32'd0);
      chk("R7 irq drops with flag", 32'(irq), 32'd0);

      // abort a slow master transfer mid-byte
      wr(1'b1, 8'h5A);
      peer_tx = 8'hC3; peer_msb = 0; peer_on = 1;
      wr(1'b0, mv(1, 0, 0, 1, 3, 1));
      repeat (200) @(negedge clk);
      wr(1'b0, mv(0, 0, 0, 1, 3, 1));
      chk("R10 clock idle after abort", 32'(sck_o), 32'd1);
      chk("R10 start cleared", 32'(mode_rd[0]), 32'd0);
      chk("R10 no flag", 32'(mode_rd[7]), 32'd0);
      peer_on = 0;
      repeat (300) @(negedge clk);
      chk("R10 no irq later", 32'(irq), 32'd0);
      master_xfer(8'h69, 8'h96, 0, 0, 1);

      // armed slave, no clock yet: busy state for write checks
      wr(1'b1, 8'hC3);
      wr(1'b0, mv(0, 1, 1, 0, 0, 1));
      wr(1'b0, mv(1, 1, 1, 0, 0, 1));
      wr(1'b1, 8'h11);
      chk("R9 data write while busy ignored", 32'(data_rd), 32'hC3);
      wr(1'b0, mv(1, 0, 0, 1, 2, 1));
      chk("R11 config unchanged while busy", 32'(mode_rd), 32'h07);
      chk("R3 clock pin input in slave mode", 32'(sck_oe), 32'd0);
      drive_ext(8'h96, 1, 4, cap);
      chk("R6 slave sent byte", 32'(cap), 32'hC3);
      chk("R6 slave received byte", 32'(data_rd), 32'h96);
      chk("R2 slave flag", 32'(mode_rd[7]), 32'd1);
      chk("R7 irq masked", 32'(irq), 32'd0);

      wr(1'b1, 8'h2D);
      wr(1'b0, mv(1, 1, 0, 1, 0, 1));
      drive_ext(8'hB4, 0, 6, cap);
      chk("R5 LSB-first slave sent", 32'(cap), 32'h2D);
      chk("R5 LSB-first slave received", 32'(data_rd), 32'hB4);
      chk("R7 irq with enable", 32'(irq), 32'd1);

      // edges while not armed are ignored
      wr(1'b1, 8'h4E);
      wr(1'b0, mv(0, 1, 0, 0, 0, 0));
      sdo_before = sdo;
      drive_ext(8'hFF, 0, 4, cap);
      chk("R6 idle edges leave data", 32'(data_rd), 32'h4E);
      chk("R6 idle edges leave sdo", 32'(sdo), 32'(sdo_before));
      chk("R6 idle edges leave flag", 32'(mode_rd[7]), 32'd0);

      repeat (4) @(negedge clk);
      summary();
   end
endmodule